// File: doc/BRIEF.md
# Five-Phase Space-Vector Segment Sequencer (Large/Medium Split)

This block produces the upper-switch states of a two-level, five-leg inverter for one centre-aligned switching period at a time. For each period it receives a sector number and two active duty fractions, alpha and beta. It divides each fraction between a large vector and a medium vector. It then plays a mirrored run of segments that starts on the all-off word, climbs through four active vectors to the all-on word in the middle, and comes back down.

An up/down carrier counter defines the period. Sector and duty inputs are captured only on the edge that starts a new period. The duty sum is clamped so that the period can never overrun. A segment of zero length is skipped, and the output word never shows an intermediate state that is not part of the sector's chain. A one-cycle strobe marks the first tick of every period.

Top module: `svpwm_2l2m_seq`

## Requirements
- R1: While reset is low, `legs_o` is 00000 and `period_start_o` is 0. Bit 4 of `legs_o` is phase a and bit 0 is phase e. A 1 means that leg's top switch is on.
- R2: One period lasts 2·2^DUTY_W clock cycles. `period_start_o` is high for exactly the first cycle of each period.
- R3: `sector_i`, `alpha_i` and `beta_i` are sampled only on the clock edge that begins a period. Changes at any other time have no effect on the period in progress.
- R4: Duties are fractions of 2^DUTY_W, and alpha+beta ≤ 2^DUTY_W. For each duty d, the large share is floor(d·2531/4096) and the medium share is d minus the large share.
- R5: Let H = 2^DUTY_W and dz = H − alpha − beta. Measured in cycles of the rising half, the half period consists of floor(dz/2) cycles of 00000, then the four active segments, then the all-on word 11111 for the remaining cycles. The falling half is the exact time mirror of the rising half.
- R6: Odd sectors play their segments in the order alpha-medium, beta-large, alpha-large, beta-medium. Even sectors play alpha-medium, alpha-large, beta-large, beta-medium.
- R6 (continued): The rising words are 10000, 11000, 11001, 11101 for sector 1 and 01000, 11000, 11100, 11101 for sector 2. For sector s+2, take the words of sector s and move every set leg one phase later (a→b→c→d→e→a).
- R7: Within a period, each change of `legs_o` from one cycle to the next either only sets bits or only clears bits. When no segment has zero length, exactly one leg changes.
- R8: A segment of zero length never appears on `legs_o`. The word moves straight to the next non-empty segment of the chain.
- R9: If alpha+beta > H, alpha is replaced by floor(alpha·H/(alpha+beta)) and beta by H minus that value. The zero time is then 0, and the period still lasts 2H cycles.
- R10: A sector code outside 1..10 holds `legs_o` at 00000 for the whole period it is sampled for. The strobe still occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sector_i | input | 4 | Sector number 1..10 for the next period |
| alpha_i | input | DUTY_W | First active duty, fraction of 2^DUTY_W |
| beta_i | input | DUTY_W | Second active duty, fraction of 2^DUTY_W |
| legs_o | output | 5 | Top-switch state per leg, a at bit 4 to e at bit 0 |
| period_start_o | output | 1 | High on the first cycle of each period |

## Verification
The bound checker watches four properties on every cycle:
- the spacing between strobes;
- that the latched thresholds stay frozen between period edges;
- that consecutive output words are nested, so legs only rise or only fall within a period;
- that the thresholds are monotonic, stay inside the half period, and give an all-zero word for an invalid sector.

Only the bench's scenarios can show that the words and their durations are correct for each of the ten sectors. The same holds for the large/medium split, the clamp of an overrun, the removal of empty segments, and the rejection of input changes in mid-period. The bench checks all of these against a model of every cycle in the period.

// File: rtl/svp_pkg.sv
package svp_pkg;

  localparam int LEGS      = 5;
  localparam int SEGS      = 5;
  localparam int SHARE_SH  = 12;
  localparam int SHARE_NUM = 2531;   // large-vector share 0.618 in Q12

  typedef logic [LEGS-1:0] leg_word_t;
  typedef logic [3:0]      sector_t;

  function automatic logic sector_ok(sector_t s);
    return (s >= 4'd1) && (s <= 4'd10);
  endfunction

  // large-vector part of an active duty
  function automatic int unsigned large_part(int unsigned d);
    return (d * SHARE_NUM) >> SHARE_SH;
  endfunction

  // index (0 = phase a) of the leg toggled at step k of sector s
  function automatic int chain_leg(sector_t s, int k);
    int j;
    int base;
    j = (int'(s) - 1) / 2;
    if (j < 0) j = 0;
    if (s[0]) begin
      case (k)
        0: base = 0;
        1: base = 1;
        2: base = 4;
        3: base = 2;
        default: base = 3;
      endcase
    end else begin
      case (k)
        0: base = 1;
        1: base = 0;
        2: base = 2;
        3: base = 4;
        default: base = 3;
      endcase
    end
    return (base + j) % LEGS;
  endfunction

  // word reached after 'level' steps up the chain of sector s
  function automatic leg_word_t chain_word(sector_t s, int level);
    leg_word_t w;
    w = '0;
    for (int k = 0; k < LEGS; k++) begin
      if (k < level) w[3'(LEGS - 1 - chain_leg(s, k))] = 1'b1;
    end
    return w;
  endfunction

endpackage

// File: rtl/svp_carrier.sv
module svp_carrier #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DUTY_W-1:0] cnt_nx,
  output logic              period_end
);

  localparam logic [DUTY_W-1:0] TOP = {DUTY_W{1'b1}};

  logic [DUTY_W-1:0] cnt_q;
  logic              up_q;
  logic              up_nx;

  always_comb begin
    cnt_nx = cnt_q;
    up_nx  = up_q;
    if (up_q) begin
      if (cnt_q == TOP) up_nx = 1'b0;
      else              cnt_nx = cnt_q + DUTY_W'(1);
    end else begin
      if (cnt_q == '0)  up_nx = 1'b1;
      else              cnt_nx = cnt_q - DUTY_W'(1);
    end
  end

  assign period_end = !up_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      up_q  <= up_nx;
    end
  end

endmodule

// File: rtl/svp_timing.sv
module svp_timing
  import svp_pkg::*;
#(
  parameter int DUTY_W = 10,
  localparam int TW    = DUTY_W + 1
) (
  input  sector_t                  sector,
  input  logic [DUTY_W-1:0]        alpha,
  input  logic [DUTY_W-1:0]        beta,
  output logic [SEGS-1:0][TW-1:0]  thr,
  output logic                     ok
);

  localparam int unsigned HALF = 32'd1 << DUTY_W;

  int unsigned a_c, b_c, dz, z;
  int unsigned al, am, bl, bm, s2, s3;

  always_comb begin
    a_c = 32'(alpha);
    b_c = 32'(beta);
    if (a_c + b_c > HALF) begin
      a_c = (a_c * HALF) / (32'(alpha) + 32'(beta));
      b_c = HALF - a_c;
    end
    dz = HALF - a_c - b_c;
    z  = dz >> 1;
    al = large_part(a_c);
    am = a_c - al;
    bl = large_part(b_c);
    bm = b_c - bl;
    s2 = sector[0] ? bl : al;
    s3 = sector[0] ? al : bl;
    thr[0] = TW'(z);
    thr[1] = TW'(z + am);
    thr[2] = TW'(z + am + s2);
    thr[3] = TW'(z + am + s2 + s3);
    thr[4] = TW'(z + am + s2 + s3 + bm);
    ok     = sector_ok(sector);
  end

endmodule

// File: rtl/svp_vector.sv
module svp_vector
  import svp_pkg::*;
#(
  parameter int DUTY_W = 10,
  localparam int TW    = DUTY_W + 1
) (
  input  logic [DUTY_W-1:0]        cnt,
  input  logic [SEGS-1:0][TW-1:0]  thr,
  input  sector_t                  sector,
  input  logic                     ok,
  output leg_word_t                word
);

  logic [SEGS-1:0] hit;

  for (genvar i = 0; i < SEGS; i++) begin : g_cmp
    assign hit[i] = ({1'b0, cnt} >= thr[i]);
  end

  always_comb begin
    word = ok ? chain_word(sector, $countones(hit)) : '0;
  end

endmodule

// File: rtl/svpwm_2l2m_seq.sv
module svpwm_2l2m_seq
  import svp_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        sector_i,
  input  logic [DUTY_W-1:0] alpha_i,
  input  logic [DUTY_W-1:0] beta_i,
  output logic [4:0]        legs_o,
  output logic              period_start_o
);

  localparam int TW = DUTY_W + 1;

  logic [DUTY_W-1:0]       cnt_nx;
  logic                    period_end;
  logic [SEGS-1:0][TW-1:0] thr_new, thr_q, thr_use;
  logic                    ok_new, sec_ok_q, ok_use;
  sector_t                 sec_q, sec_use;
  leg_word_t               word_nx;
  logic                    strobe_q;
  leg_word_t               legs_q;

  svp_carrier #(.DUTY_W(DUTY_W)) u_carrier (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_nx    (cnt_nx),
    .period_end(period_end)
  );

  svp_timing #(.DUTY_W(DUTY_W)) u_timing (
    .sector(sector_i),
    .alpha (alpha_i),
    .beta  (beta_i),
    .thr   (thr_new),
    .ok    (ok_new)
  );

  assign thr_use = period_end ? thr_new  : thr_q;
  assign ok_use  = period_end ? ok_new   : sec_ok_q;
  assign sec_use = period_end ? sector_i : sec_q;

  svp_vector #(.DUTY_W(DUTY_W)) u_vector (
    .cnt   (cnt_nx),
    .thr   (thr_use),
    .sector(sec_use),
    .ok    (ok_use),
    .word  (word_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q    <= '0;
      sec_q    <= '0;
      sec_ok_q <= 1'b0;
      legs_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      thr_q    <= thr_use;
      sec_q    <= sec_use;
      sec_ok_q <= ok_use;
      legs_q   <= word_nx;
      strobe_q <= period_end;
    end
  end

  assign legs_o         = legs_q;
  assign period_start_o = strobe_q;

endmodule

// File: rtl/svpwm_2l2m_seq_chk.sv
module svpwm_2l2m_seq_chk #(
  parameter int DUTY_W = 10,
  localparam int TW    = DUTY_W + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [4:0]           legs,
  input logic                 strobe,
  input logic                 load,
  input logic [4:0][TW-1:0]   thr,
  input logic                 ok
);

  localparam int GW = DUTY_W + 2;
  localparam logic [GW-1:0] GAP_EXP = GW'((2 << DUTY_W) - 1);
  localparam logic [TW-1:0] HALF    = TW'(1 << DUTY_W);

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (strobe) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap  <= gap + GW'(1);
    end
  end

  assert_period_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && seen) |-> (gap == GAP_EXP));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  assert_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(thr) && $stable(ok)));

  assert_nested_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (((legs & $past(legs)) == $past(legs)) ||
                 ((legs & $past(legs)) == legs)));

  assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thr[4] <= HALF);

  for (genvar i = 0; i < 4; i++) begin : g_mono
    assert_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
      thr[i] <= thr[i+1]);
  end

  assert_bad_sector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ok |-> (legs == 5'b00000));

endmodule

bind svpwm_2l2m_seq svpwm_2l2m_seq_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .legs  (legs_o),
  .strobe(period_start_o),
  .load  (period_end),
  .thr   (thr_q),
  .ok    (sec_ok_q)
);

// File: tb/svpwm_2l2m_seq_tb.sv
module svpwm_2l2m_seq_tb;

  localparam int DW = 6;
  localparam int H  = 1 << DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    sector_i = 4'd1;
  logic [DW-1:0] alpha_i = '0;
  logic [DW-1:0] beta_i = '0;
  logic [4:0]    legs_o;
  logic          period_start_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  svpwm_2l2m_seq #(.DUTY_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sector_i(sector_i), .alpha_i(alpha_i),
    .beta_i(beta_i), .legs_o(legs_o), .period_start_o(period_start_o)
  );

  // rising-half words per sector (R6), written out
  function automatic logic [19:0] chain_tb(int s);
    case (s)
      1:  return {5'b10000, 5'b11000, 5'b11001, 5'b11101};
      2:  return {5'b01000, 5'b11000, 5'b11100, 5'b11101};
      3:  return {5'b01000, 5'b01100, 5'b11100, 5'b11110};
      4:  return {5'b00100, 5'b01100, 5'b01110, 5'b11110};
      5:  return {5'b00100, 5'b00110, 5'b01110, 5'b01111};
      6:  return {5'b00010, 5'b00110, 5'b00111, 5'b01111};
      7:  return {5'b00010, 5'b00011, 5'b00111, 5'b10111};
      8:  return {5'b00001, 5'b00011, 5'b10011, 5'b10111};
      9:  return {5'b00001, 5'b10001, 5'b10011, 5'b11011};
      default: return {5'b10000, 5'b10001, 5'b11001, 5'b11011};
    endcase
  endfunction

  task automatic check(string tag, logic [5:0] got, logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got strobe/legs=%b expected %b", tag, got, exp);
    end
  endtask

  // driver: after a strobe, present inputs for the next period and push its words
  task automatic drive_period(int s, int a, int b, string tag, bit wiggle);
    int aa, bb, dz, al, am, bl, bm, t, seg;
    int len[6];
    logic [4:0] wd[6];
    logic [4:0] half[H];
    logic [19:0] ch;
    @(negedge clk);
    while (!period_start_o) @(negedge clk);
    #1;
    sector_i = 4'(s); alpha_i = DW'(a); beta_i = DW'(b);
    aa = a; bb = b;
    if (aa + bb > H) begin          // R9 clamp
      aa = (aa * H) / (a + b);
      bb = H - aa;
    end
    dz = H - aa - bb;
    al = (aa * 2531) / 4096; am = aa - al;   // R4
    bl = (bb * 2531) / 4096; bm = bb - bl;
    ch = chain_tb(s);
    len[0] = dz / 2;                wd[0] = 5'b00000;
    len[1] = am;                    wd[1] = ch[19:15];
    len[2] = (s % 2) ? bl : al;     wd[2] = ch[14:10];
    len[3] = (s % 2) ? al : bl;     wd[3] = ch[9:5];
    len[4] = bm;                    wd[4] = ch[4:0];
    len[5] = H - len[0] - aa - bb;  wd[5] = 5'b11111;
    t = 0;
    for (int k = 0; k < 6; k++) begin
      for (int n = 0; n < len[k]; n++) begin
        half[t] = wd[k];
        t++;
      end
    end
    for (int i = 0; i < 2 * H; i++) begin
      logic [4:0] w;
      w = (i < H) ? half[i] : half[2 * H - 1 - i];
      if (s < 1 || s > 10) w = 5'b00000;     // R10
      exp_q.push_back({(i == 0), w});
      tag_q.push_back(tag);
    end
    if (wiggle) begin                      // R3: mid-period changes ignored
      repeat (40) @(negedge clk);
      sector_i = 4'(s ^ 5); alpha_i = ~DW'(a); beta_i = ~DW'(b);
      repeat (30) @(negedge clk);
      sector_i = 4'(s); alpha_i = DW'(a); beta_i = DW'(b);
    end
    seg = 0;
  endtask

  // monitor: pops one expected item per cycle once aligned on a strobe
  initial begin
    bit synced = 0;
    forever begin
      @(negedge clk);
      if (!synced && period_start_o && exp_q.size() > 0) synced = 1;
      if (synced) begin
        check(tag_q.pop_front(), {period_start_o, legs_o}, exp_q.pop_front());
        if (exp_q.size() == 0) synced = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {period_start_o, legs_o}, 6'b000000);
    repeat (2) @(negedge clk);
    check("R1 reset", {period_start_o, legs_o}, 6'b000000);
    #1 rst_n = 1'b1;
    for (int s = 1; s <= 10; s++) drive_period(s, 20, 15, "R6 sector chain", 0);
    drive_period(3, 40, 24, "R5 R8 no zero time", 0);
    drive_period(7, 10, 10, "R4 split", 0);
    drive_period(2, 50, 40, "R9 overrun", 0);
    drive_period(8, 63, 63, "R9 overrun max", 0);
    drive_period(5, 0, 30, "R8 empty alpha", 0);
    drive_period(6, 30, 0, "R8 empty beta", 0);
    drive_period(9, 1, 1, "R7 small duties", 0);
    drive_period(0, 20, 20, "R10 sector zero", 0);
    drive_period(12, 20, 20, "R10 sector twelve", 0);
    drive_period(4, 25, 12, "R3 mid-period change", 1);
    drive_period(1, 0, 0, "R5 all zero time", 0);
    drive_period(10, 33, 17, "R2 R5 period", 0);
    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule